// File: doc/BRIEF.md
# Buffer Command Bus Serializer

The serializer sits in the central register of a buffered memory module and feeds the narrow command bus that runs to each data buffer. There are two request channels, and each uses a valid/ready handshake. One channel carries buffer control words and mode-register mirrors. The other carries read and write mirrors, which let the data buffers follow the state of the memory devices.

Each accepted command becomes a frame of six bus cycles. The first five are 4-bit data beats and the sixth is a parity beat. The frames can run back to back. Between frames the bus shows a fixed no-operation pattern.

The nine bus signals are four data lines, one parity line and four framing lines. A command is captured in the cycle it is accepted. Its first beat appears on the bus in the following cycle. The router may change its inputs freely once the handshake has completed.

Top module: `bcbus_serializer`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, rw_ready is 1 and the bus is idle: bus_dat is 4'b1111, bus_par is 0 and bus_ctl is 0.
- R2: A command accepted at a clock edge appears starting in the next cycle, as five data beats.
  - Beat 0 is the type code: 4'b0001 for a buffer control word, 4'b0010 for a mode-register mirror, 4'b0100 for a read, 4'b1000 for a write.
  - Beats 1, 2 and 3 carry address bits 11:8, 7:4 and 3:0.
  - Beat 4 carries rw_qual for a read or write, and 4'b0000 for the control channel.
- R3: rw_ready is 1 exactly when no data beat remains to be driven, that is, when the bus is idle or shows a parity beat. A channel transfers on a clock edge where its valid and its ready are both 1.
- R4: On the framing lines:
  - bus_ctl[0] is 1 on beat 0 only.
  - bus_ctl[1] is 1 on all six beats of a frame.
  - bus_ctl[2] is 1 on the parity beat only.
  - bus_ctl[3] is 1 on all six beats of a read or write frame and 0 otherwise.
- R5: On the parity beat, bus_dat is 4'b0000 and bus_par is the XOR of the 20 data bits of the frame (even parity). At every other time bus_par is 0.
- R6: The read/write channel has priority. cw_ready is 0 whenever rw_valid is 1, so a control word requested in the same cycle as a read or write waits.
- R7: Outside a frame, bus_dat is 4'b1111, bus_par is 0 and bus_ctl is 0.
- R8: A command presented during a parity beat is accepted there. Its beat 0 appears in the very next cycle, with no idle cycle in between.
- R9: Changing any request input after acceptance has no effect on the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_valid | input | 1 | Control-channel request |
| cw_ready | output | 1 | Control-channel accept |
| cw_mrs | input | 1 | 1 = mode-register mirror, 0 = buffer control word |
| cw_addr | input | 12 | Control-channel address payload |
| rw_valid | input | 1 | Read/write mirror request |
| rw_ready | output | 1 | Read/write accept (serializer free) |
| rw_wr | input | 1 | 1 = write, 0 = read |
| rw_addr | input | 12 | Read/write address payload |
| rw_qual | input | 4 | Bank/rank qualifier for beat 4 |
| bus_dat | output | 4 | Bus data lines |
| bus_par | output | 1 | Bus parity line |
| bus_ctl | output | 4 | Framing lines: start, busy, parity beat, read/write |

## Verification
The bench sends isolated commands of each of the four types, with distinct payloads. This separates the type codes, the nibble order and the beat-4 qualifier rule.

It then raises both channels in the same cycle, which tells the priority rule apart from a plain first-come order. It also holds requests valid continuously, which exposes any idle gap between frames.

The payload is altered in the middle of a frame to show that the captured copy is used. A long stretch of random requests then mixes arrival phases against the parity beat, and every cycle is compared with a queue-based model.

// File: rtl/bcbus_serializer.sv
module bcbus_serializer #(
  parameter int BEAT_W     = 4,
  parameter int ADDR_BEATS = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cw_valid,
  output logic                         cw_ready,
  input  logic                         cw_mrs,
  input  logic [BEAT_W*ADDR_BEATS-1:0] cw_addr,
  input  logic                         rw_valid,
  output logic                         rw_ready,
  input  logic                         rw_wr,
  input  logic [BEAT_W*ADDR_BEATS-1:0] rw_addr,
  input  logic [BEAT_W-1:0]            rw_qual,
  output logic [BEAT_W-1:0]            bus_dat,
  output logic                         bus_par,
  output logic [3:0]                   bus_ctl
);
  localparam int DATA_BEATS  = ADDR_BEATS + 2;
  localparam int FRAME_BEATS = DATA_BEATS + 1;
  localparam int FRAME_W     = BEAT_W * DATA_BEATS;
  localparam int CNT_W       = $clog2(FRAME_BEATS + 1);
  localparam logic [BEAT_W-1:0] T_BCW = BEAT_W'(1);
  localparam logic [BEAT_W-1:0] T_MRS = BEAT_W'(2);
  localparam logic [BEAT_W-1:0] T_RD  = BEAT_W'(4);
  localparam logic [BEAT_W-1:0] T_WR  = BEAT_W'(8);
  localparam logic [BEAT_W-1:0] NOP   = {BEAT_W{1'b1}};

  logic [CNT_W-1:0]   beat;
  logic [FRAME_W-1:0] frame, new_frame;
  logic               par_q, is_rw;

  wire busy = beat != '0;
  wire last = beat == CNT_W'(FRAME_BEATS);
  wire take = rw_ready && (rw_valid || cw_valid);

  assign rw_ready = !busy || last;
  assign cw_ready = rw_ready && !rw_valid;

  always_comb begin
    if (rw_valid) new_frame = {rw_wr ? T_WR : T_RD, rw_addr, rw_qual};
    else          new_frame = {cw_mrs ? T_MRS : T_BCW, cw_addr, {BEAT_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat  <= '0;
      frame <= '0;
      par_q <= 1'b0;
      is_rw <= 1'b0;
    end else if (take) begin
      beat  <= CNT_W'(1);
      frame <= new_frame;
      par_q <= ^new_frame;
      is_rw <= rw_valid;
    end else if (busy) begin
      beat  <= last ? '0 : beat + CNT_W'(1);
      frame <= frame << BEAT_W;
    end
  end

  assign bus_dat = !busy ? NOP : last ? '0 : frame[FRAME_W-1 -: BEAT_W];
  assign bus_par = last && par_q;
  assign bus_ctl = {busy && is_rw, last, busy, beat == CNT_W'(1)};
endmodule

module bcbus_serializer_chk #(
  parameter int BEAT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cw_ready,
  input logic              rw_valid,
  input logic              rw_ready,
  input logic              cw_valid,
  input logic [BEAT_W-1:0] bus_dat,
  input logic              bus_par,
  input logic [3:0]        bus_ctl
);
  logic acc;
  always_ff @(posedge clk) begin
    if (!rst_n)          acc <= 1'b0;
    else if (bus_ctl[2]) acc <= 1'b0;
    else if (bus_ctl[1]) acc <= acc ^ (^bus_dat);
  end

  assert_handshake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_ready && (rw_valid || cw_valid)) |=> bus_ctl[0]);
  assert_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rw_valid |-> !cw_ready);
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ctl[1] |-> (bus_dat == {BEAT_W{1'b1}} && !bus_par && bus_ctl == 4'b0));
  assert_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ctl[2] |-> (bus_par == acc && bus_dat == '0));
  assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ctl[0] |=> (bus_ctl[1] && !bus_ctl[0] && !bus_ctl[2]));
  assert_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ctl[1] && !bus_ctl[2]) |-> !rw_ready);
endmodule

bind bcbus_serializer bcbus_serializer_chk #(.BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cw_ready(cw_ready), .rw_valid(rw_valid),
  .rw_ready(rw_ready), .cw_valid(cw_valid), .bus_dat(bus_dat),
  .bus_par(bus_par), .bus_ctl(bus_ctl));

// File: tb/sim_bcbus_serializer.sv
module sim_bcbus_serializer;
  logic clk = 0, rst_n = 0;
  logic cw_valid = 0, cw_mrs = 0, rw_valid = 0, rw_wr = 0;
  logic [11:0] cw_addr = 0, rw_addr = 0;
  logic [3:0] rw_qual = 0;
  logic cw_ready, rw_ready, bus_par;
  logic [3:0] bus_dat, bus_ctl;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bcbus_serializer u0 (.clk, .rst_n, .cw_valid, .cw_ready, .cw_mrs, .cw_addr,
    .rw_valid, .rw_ready, .rw_wr, .rw_addr, .rw_qual, .bus_dat, .bus_par, .bus_ctl);

  // model word: {ctl[3:0], par, dat[3:0]}
  localparam logic [8:0] IDLE = {4'b0000, 1'b0, 4'b1111};
  logic [8:0] q[$];
  logic [8:0] cur = IDLE, prev = IDLE;

  task automatic push_frame(input logic [3:0] code, input logic [11:0] a,
                            input logic [3:0] b4, input logic rw);
    logic [3:0] n[5];
    int ones = 0;
    n[0] = code; n[1] = a[11:8]; n[2] = a[7:4]; n[3] = a[3:0]; n[4] = b4;
    for (int i = 0; i < 5; i++)
      for (int k = 0; k < 4; k++) ones += n[i][k];
    for (int i = 0; i < 5; i++)
      q.push_back({rw, 1'b0, 1'b1, (i == 0), 1'b0, n[i]});
    q.push_back({rw, 1'b1, 1'b1, 1'b0, 1'(ones % 2), 4'b0000});
  endtask

  always @(posedge clk) begin
    prev = cur;
    if (!rst_n) begin
      q.delete();
      cur = IDLE;
    end else begin
      if (q.size() == 0) begin
        if (rw_valid)      push_frame(rw_wr ? 4'b1000 : 4'b0100, rw_addr, rw_qual, 1'b1);
        else if (cw_valid) push_frame(cw_mrs ? 4'b0010 : 4'b0001, cw_addr, 4'b0000, 1'b0);
      end
      cur = (q.size() != 0) ? q.pop_front() : IDLE;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic exp_rdy;
    exp_rdy = !rst_n || (q.size() == 0);
    if (!rst_n) begin
      chk("R1 bus", {bus_ctl, bus_par, bus_dat}, IDLE);
      chk("R1 ready", rw_ready, 1);
    end else begin
      if (cur == IDLE)                     chk("R7 idle", {bus_ctl, bus_par, bus_dat}, cur);
      else if (cur[7])                     chk("R5 parity", {bus_par, bus_dat}, cur[4:0]);
      else if (cur[5] && prev[7])          chk("R8 back-to-back", {bus_ctl, bus_dat}, {cur[8:5], cur[3:0]});
      else                                 chk("R2 R9 beat", {bus_par, bus_dat}, cur[4:0]);
      chk("R4 ctl", bus_ctl, cur[8:5]);
      chk("R3 rw_ready", rw_ready, exp_rdy);
      chk("R6 cw_ready", cw_ready, exp_rdy && !rw_valid);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(2);
    // R2: buffer control word
    cw_valid = 1; cw_mrs = 0; cw_addr = 12'hA5C; step(1);
    cw_valid = 0;
    cw_addr = 12'h3F0;   // R9: payload changed mid-frame
    step(8);
    // R2: mode-register mirror
    cw_valid = 1; cw_mrs = 1; cw_addr = 12'h7E1; step(1); cw_valid = 0; step(8);
    // R2: read then write with qualifier
    rw_valid = 1; rw_wr = 0; rw_addr = 12'h123; rw_qual = 4'h9; step(1);
    rw_valid = 0; rw_addr = 12'hFFF; rw_qual = 4'h0; step(8);
    rw_valid = 1; rw_wr = 1; rw_addr = 12'hC0D; rw_qual = 4'h6; step(1); rw_valid = 0; step(8);
    // R6: both channels in the same cycle
    rw_valid = 1; rw_wr = 0; rw_addr = 12'h0F0; cw_valid = 1; cw_mrs = 0; cw_addr = 12'h111;
    step(1); rw_valid = 0; step(14); cw_valid = 0; step(4);
    // R8: continuous requests, frames back to back
    rw_valid = 1;
    for (int i = 0; i < 20; i++) begin rw_wr = i[0]; rw_addr = 12'(i * 37); step(1); end
    rw_valid = 0; step(8);
    // random traffic
    for (int i = 0; i < 400; i++) begin
      rw_valid = ($urandom % 4) == 0; rw_wr = $urandom; rw_addr = 12'($urandom);
      rw_qual = 4'($urandom); cw_valid = ($urandom % 3) == 0; cw_mrs = $urandom;
      cw_addr = 12'($urandom);
      step(1);
    end
    rw_valid = 0; cw_valid = 0; step(8);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule